// File: doc/BRIEF.md
# Doorbell Interrupt Decoder and Router

This block sits behind a RapidIO receive path and takes doorbell packets that have already been deframed. Each packet arrives as parallel header fields plus its 16-bit info word, one packet for each cycle in which `pkt_valid_i` is high. The block checks that the packet is a doorbell and that no reserved info bit is set. From the info word it picks one of 64 pending-interrupt flags, held as four 16-bit status words, and sets that flag.

Every flag has its own 4-bit routing code. The code steers the flag to one of eight level interrupt lines or to none. A small register port lets software read the status words, clear flags, and program the routing codes. A malformed doorbell sets no flag. Instead it raises an error-response request for one cycle, together with the source ID and transaction ID that the response needs.

Top module: `doorbell_irq_router`

## Requirements
- R1: A packet whose 4-bit format type is not 1010b is ignored: no status bit changes and `err_req_o` stays low.
- R2: A valid doorbell with clean reserved bits sets status bit `info[3:0]` of status word `info[6:5]`. The bit is readable on the first cycle after the clock edge that samples the packet. Examples: info 0x0027 sets bit 7 of word 1, and info 0x006B sets bit 11 of word 3.
- R3: Info bits [15:7] and bit [4] are reserved. If a doorbell has any of them set, no status bit changes. On the next cycle `err_req_o` is high for exactly one cycle, and `err_src_id_o`/`err_src_tid_o` carry the rejected packet's source ID and transaction ID.
- R4: The 2-bit priority field has no effect on which status bit is set.
- R5: Writing to a word's clear address clears every status bit of that word whose data bit is 1. Bits written as 0 are unchanged.
- R6: When a doorbell set and a clear hit the same bit in the same cycle, the bit ends up set.
- R7: For status bit n of word k, the routing code is held in bits [4(n mod 8)+3 : 4(n mod 8)]. For n below 8 these bits are in word k's low routing register; for n of 8 or above they are in its high routing register.
- R8: `irq_o[j]` is high while at least one set status bit has routing code j. Codes 8 to 15 drive no line.
- R9: After reset all status bits and routing registers are 0, so every status bit routes to `irq_o[0]`.
- R10: Register address [3:2] selects the word and [1:0] selects the kind: 0 is status, 1 is clear, 2 is low routing, 3 is high routing. Writes to a status address have no effect. A clear address reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_valid_i | input | 1 | Packet fields valid this cycle |
| pkt_ftype_i | input | 4 | Packet format type |
| pkt_prio_i | input | 2 | Packet priority |
| pkt_src_id_i | input | 8 | Source device ID |
| pkt_src_tid_i | input | 8 | Source transaction ID |
| pkt_info_i | input | 16 | Doorbell info word |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from address) |
| irq_o | output | 8 | Level interrupt lines |
| err_req_o | output | 1 | One-cycle error-response request |
| err_src_id_o | output | 8 | Source ID of last rejected doorbell |
| err_src_tid_o | output | 8 | Transaction ID of last rejected doorbell |

## Verification
A wrong flag index or a lost set shows up at the ports one cycle after the packet. It appears on the status read-back, and it moves or drops an interrupt line. A corrupted routing code shows up on `irq_o` as soon as any flag routed through that code is pending. The bench keeps a behavioural copy of the status words and routing codes. On every cycle it compares the interrupt lines, the error outputs and the read data for the current address against that copy, so a divergence is reported in the cycle it first becomes visible.

// File: rtl/doorbell_irq_pkg.sv
package doorbell_irq_pkg;
  localparam logic [3:0]  FTYPE_DOORBELL = 4'b1010;
  localparam logic [15:0] INFO_RSV_MASK  = 16'hFF90;
  localparam int unsigned INFO_WORD_LSB  = 5;
  localparam int unsigned INFO_WORD_W    = 2;
  localparam int unsigned INFO_BIT_W     = 4;

  typedef enum logic [1:0] {
    RK_STATUS   = 2'd0,
    RK_CLEAR    = 2'd1,
    RK_ROUTE_LO = 2'd2,
    RK_ROUTE_HI = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/db_info_decode.sv
module db_info_decode
  import doorbell_irq_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             valid_i,
  input  logic [3:0]       ftype_i,
  input  logic [15:0]      info_i,
  output logic             set_o,
  output logic             rsv_err_o,
  output logic [IDX_W-1:0] idx_o
);
  logic is_db, rsv_hit;

  always_comb begin
    is_db     = valid_i && (ftype_i == FTYPE_DOORBELL);
    rsv_hit   = |(info_i & INFO_RSV_MASK);
    set_o     = is_db && !rsv_hit;
    rsv_err_o = is_db && rsv_hit;
    idx_o     = IDX_W'({info_i[INFO_WORD_LSB +: INFO_WORD_W], info_i[INFO_BIT_W-1:0]});
  end
endmodule

// File: rtl/db_status_bank.sv
module db_status_bank #(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned WORD_W    = 16,
  localparam int unsigned NUM_SRC  = NUM_WORDS * WORD_W,
  localparam int unsigned IDX_W    = $clog2(NUM_SRC)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_i,
  input  logic [IDX_W-1:0]     set_idx_i,
  input  logic [NUM_WORDS-1:0] clr_we_i,
  input  logic [WORD_W-1:0]    clr_data_i,
  output logic [NUM_SRC-1:0]   status_o
);
  logic [NUM_SRC-1:0] set_vec;

  always_comb begin
    set_vec = '0;
    if (set_i) set_vec[set_idx_i] = 1'b1;
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q, clr_mask;
    assign clr_mask = clr_we_i[w] ? clr_data_i : '0;

    // set is applied after clear so it wins
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '0;
      else         word_q <= (word_q & ~clr_mask) | set_vec[w*WORD_W +: WORD_W];
    end

    assign status_o[w*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/db_route_map.sv
module db_route_map #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned ROUTE_W = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_IRQ = 8,
  localparam int unsigned NUM_RREG = NUM_SRC * ROUTE_W / DATA_W,
  localparam int unsigned RSEL_W   = $clog2(NUM_RREG)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [RSEL_W-1:0]           wr_sel_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  input  logic [NUM_SRC-1:0]          status_i,
  output logic [NUM_SRC*ROUTE_W-1:0]  route_o,
  output logic [NUM_IRQ-1:0]          irq_o
);
  for (genvar r = 0; r < NUM_RREG; r++) begin : g_rreg
    logic [DATA_W-1:0] rreg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        rreg_q <= '0;
      else if (wr_en_i && wr_sel_i == RSEL_W'(r))         rreg_q <= wr_data_i;
    end
    assign route_o[r*DATA_W +: DATA_W] = rreg_q;
  end

  // source s uses code field s of the flattened routing vector
  always_comb begin
    irq_o = '0;
    for (int j = 0; j < NUM_IRQ; j++) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (status_i[s] && route_o[s*ROUTE_W +: ROUTE_W] == ROUTE_W'(j)) irq_o[j] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/doorbell_irq_router.sv
module doorbell_irq_router
  import doorbell_irq_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned ROUTE_W   = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_IRQ   = 8,
  localparam int unsigned NUM_SRC  = NUM_WORDS * WORD_W,
  localparam int unsigned IDX_W    = $clog2(NUM_SRC),
  localparam int unsigned WSEL_W   = $clog2(NUM_WORDS),
  localparam int unsigned ADDR_W   = WSEL_W + 2,
  localparam int unsigned NUM_RREG = NUM_SRC * ROUTE_W / DATA_W,
  localparam int unsigned RSEL_W   = $clog2(NUM_RREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pkt_valid_i,
  input  logic [3:0]         pkt_ftype_i,
  input  logic [1:0]         pkt_prio_i,
  input  logic [7:0]         pkt_src_id_i,
  input  logic [7:0]         pkt_src_tid_i,
  input  logic [15:0]        pkt_info_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic [NUM_IRQ-1:0] irq_o,
  output logic               err_req_o,
  output logic [7:0]         err_src_id_o,
  output logic [7:0]         err_src_tid_o
);
  logic                       set_w, rsv_err_w;
  logic [IDX_W-1:0]           set_idx_w;
  logic [NUM_SRC-1:0]         status_w;
  logic [NUM_SRC*ROUTE_W-1:0] route_w;
  logic [NUM_WORDS-1:0]       clr_we_w;
  logic                       rwr_en_w;
  logic [RSEL_W-1:0]          rwr_sel_w;
  reg_kind_e                  kind_w;
  logic [WSEL_W-1:0]          wsel_w;

  assign kind_w = reg_kind_e'(reg_addr_i[1:0]);
  assign wsel_w = reg_addr_i[ADDR_W-1:2];

  db_info_decode #(.IDX_W(IDX_W)) u_dec (
    .valid_i   (pkt_valid_i),
    .ftype_i   (pkt_ftype_i),
    .info_i    (pkt_info_i),
    .set_o     (set_w),
    .rsv_err_o (rsv_err_w),
    .idx_o     (set_idx_w)
  );

  always_comb begin
    clr_we_w = '0;
    if (reg_we_i && kind_w == RK_CLEAR) clr_we_w[wsel_w] = 1'b1;
    rwr_en_w  = reg_we_i && (kind_w == RK_ROUTE_LO || kind_w == RK_ROUTE_HI);
    rwr_sel_w = RSEL_W'({wsel_w, reg_addr_i[0]});
  end

  db_status_bank #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_w),
    .set_idx_i  (set_idx_w),
    .clr_we_i   (clr_we_w),
    .clr_data_i (reg_wdata_i[WORD_W-1:0]),
    .status_o   (status_w)
  );

  db_route_map #(.NUM_SRC(NUM_SRC), .ROUTE_W(ROUTE_W), .DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ)) u_route (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (rwr_en_w),
    .wr_sel_i  (rwr_sel_w),
    .wr_data_i (reg_wdata_i),
    .status_i  (status_w),
    .route_o   (route_w),
    .irq_o     (irq_o)
  );

  always_comb begin
    unique case (kind_w)
      RK_STATUS:   reg_rdata_o = DATA_W'(status_w[wsel_w*WORD_W +: WORD_W]);
      RK_CLEAR:    reg_rdata_o = '0;
      default:     reg_rdata_o = route_w[rwr_sel_w*DATA_W +: DATA_W];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_req_o     <= 1'b0;
      err_src_id_o  <= '0;
      err_src_tid_o <= '0;
    end else begin
      err_req_o <= rsv_err_w;
      if (rsv_err_w) begin
        err_src_id_o  <= pkt_src_id_i;
        err_src_tid_o <= pkt_src_tid_i;
      end
    end
  end
endmodule

// File: rtl/doorbell_irq_router_chk.sv
module doorbell_irq_router_chk
  import doorbell_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned NUM_IRQ = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pkt_valid_i,
  input logic [3:0]         pkt_ftype_i,
  input logic [1:0]         pkt_prio_i,
  input logic [7:0]         pkt_src_id_i,
  input logic [7:0]         pkt_src_tid_i,
  input logic [15:0]        pkt_info_i,
  input logic               reg_we_i,
  input logic [NUM_IRQ-1:0] irq_o,
  input logic               err_req_o,
  input logic [7:0]         err_src_id_o,
  input logic [7:0]         err_src_tid_o,
  input logic [NUM_SRC-1:0] status_i
);
  logic is_db, rsv;
  logic exp_set_q;
  logic [IDX_W-1:0] exp_idx_q;

  assign is_db = pkt_valid_i && pkt_ftype_i == FTYPE_DOORBELL;
  assign rsv   = |(pkt_info_i & INFO_RSV_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_set_q <= 1'b0;
      exp_idx_q <= '0;
    end else begin
      exp_set_q <= is_db && !rsv;
      exp_idx_q <= IDX_W'({pkt_info_i[6:5], pkt_info_i[3:0]});
    end
  end

  AST_SET_ADDRESSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_set_q |-> status_i[exp_idx_q]);                                         // R2
  AST_NONDB_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && pkt_ftype_i != FTYPE_DOORBELL && !reg_we_i) |=> ($stable(status_i) && !err_req_o)); // R1
  AST_RSV_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_db && rsv && !reg_we_i) |=> $stable(status_i));                        // R3
  AST_RSV_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_db && rsv) |=> (err_req_o && err_src_id_o == $past(pkt_src_id_i)
                        && err_src_tid_o == $past(pkt_src_tid_i)));            // R3
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_req_o |-> $past(is_db && rsv));                                         // R3
  AST_IDLE_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == '0) |-> (irq_o == '0));                                        // R8
  AST_IRQ_NEEDS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(irq_o) <= $countones(status_i));                                 // R8
endmodule

bind doorbell_irq_router doorbell_irq_router_chk #(.NUM_SRC(NUM_SRC), .NUM_IRQ(NUM_IRQ)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pkt_valid_i   (pkt_valid_i),
  .pkt_ftype_i   (pkt_ftype_i),
  .pkt_prio_i    (pkt_prio_i),
  .pkt_src_id_i  (pkt_src_id_i),
  .pkt_src_tid_i (pkt_src_tid_i),
  .pkt_info_i    (pkt_info_i),
  .reg_we_i      (reg_we_i),
  .irq_o         (irq_o),
  .err_req_o     (err_req_o),
  .err_src_id_o  (err_src_id_o),
  .err_src_tid_o (err_src_tid_o),
  .status_i      (status_w)
);

// File: tb/doorbell_irq_router_tb_top.sv
`timescale 1ns/100ps
module doorbell_irq_router_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        valid;
  logic [3:0]  ftype;
  logic [1:0]  prio;
  logic [7:0]  sid, stid;
  logic [15:0] info;
  logic        we;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic [7:0]  irq;
  logic        err;
  logic [7:0]  eid, etid;

  doorbell_irq_router dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pkt_valid_i(valid), .pkt_ftype_i(ftype), .pkt_prio_i(prio),
    .pkt_src_id_i(sid), .pkt_src_tid_i(stid), .pkt_info_i(info), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
    .err_req_o(err), .err_src_id_o(eid), .err_src_tid_o(etid)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference
  logic [15:0] m_st [4];
  logic [31:0] m_rt [8];
  logic        m_err;
  logic [7:0]  m_eid, m_etid;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_st[i]) m_st[i] = '0;
      foreach (m_rt[i]) m_rt[i] = '0;
      m_err = 0; m_eid = 0; m_etid = 0;
    end else begin
      m_err = 0;
      if (we) begin
        if (addr[1:0] == 2'd1) m_st[addr[3:2]] = m_st[addr[3:2]] & ~wdata[15:0];
        if (addr[1]) m_rt[{addr[3:2], addr[0]}] = wdata;
      end
      if (valid && ftype == 4'b1010) begin
        if ((info & 16'hFF90) != 0) begin
          m_err = 1; m_eid = sid; m_etid = stid;
        end else m_st[info[6:5]][info[3:0]] = 1'b1;
      end
    end
  end

  function automatic logic [7:0] m_irq();
    logic [7:0] v = '0;
    for (int w = 0; w < 4; w++)
      for (int b = 0; b < 16; b++) begin
        int code = (m_rt[w*2 + b/8] >> (4*(b%8))) & 15;
        if (m_st[w][b] && code < 8) v[code] = 1'b1;
      end
    return v;
  endfunction

  function automatic logic [31:0] m_rd(logic [3:0] a);
    case (a[1:0])
      2'd0:    return {16'h0, m_st[a[3:2]]};
      2'd1:    return '0;
      default: return m_rt[{a[3:2], a[0]}];
    endcase
  endfunction

  always @(negedge clk) if (rst_n && !done) begin
    chk("R8 irq vs model", irq, m_irq());
    chk("R3 err vs model", err, m_err);
    chk("R3 err ids vs model", {eid, etid}, {m_eid, m_etid});
    chk("R10 rdata vs model", rdata, m_rd(addr));
  end

  task automatic tick();
    @(negedge clk); #0.5;
  endtask

  task automatic idle();
    valid = 0; we = 0;
  endtask

  task automatic pkt(logic [3:0] ft, logic [1:0] pr, logic [15:0] inf, logic [7:0] s, logic [7:0] t);
    valid = 1; ftype = ft; prio = pr; info = inf; sid = s; stid = t;
    tick(); idle();
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    we = 1; addr = a; wdata = d;
    tick(); idle();
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
    addr = a; #0.5;
    chk(req, rdata, exp);
  endtask

  initial begin
    #150000;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; valid = 0; ftype = 0; prio = 0; sid = 0; stid = 0; info = 0;
    we = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    rd_chk("R9 status reset", 4'h0, 0);
    rd_chk("R9 route reset", 4'h2, 0);
    chk("R9 irq reset", irq, 0);

    pkt(4'b1010, 0, 16'h0000, 8'h11, 8'h01);
    rd_chk("R2 word0 bit0", 4'h0, 32'h1);
    chk("R9 default route to irq0", irq, 8'h01);
    pkt(4'b1010, 2, 16'h0027, 8'h12, 8'h02);
    rd_chk("R2 R4 info 0x0027", 4'h4, 32'h0080);
    pkt(4'b1010, 0, 16'h006B, 8'h13, 8'h03);
    rd_chk("R2 R4 info 0x006B", 4'hC, 32'h0800);
    pkt(4'b1010, 3, 16'h0045, 8'h14, 8'h04);
    rd_chk("R2 R4 info 0x0045", 4'h8, 32'h0020);

    pkt(4'h5, 0, 16'h0001, 8'h15, 8'h05);
    chk("R1 non-doorbell no err", err, 0);
    rd_chk("R1 non-doorbell no set", 4'h0, 32'h1);

    pkt(4'b1010, 1, 16'h0010, 8'h3C, 8'h5A);
    chk("R3 err on bit4", err, 1);
    chk("R3 err ids", {eid, etid}, 16'h3C5A);
    rd_chk("R3 no set", 4'h0, 32'h1);
    tick();
    chk("R3 err one cycle", err, 0);
    pkt(4'b1010, 0, 16'h8000, 8'h77, 8'h88);
    chk("R3 err on bit15", err, 1);
    chk("R3 err ids 2", {eid, etid}, 16'h7788);

    wr(4'h6, 32'h3000_0000);
    rd_chk("R7 route readback", 4'h6, 32'h3000_0000);
    chk("R7 word1 bit7 to irq3", irq, 8'h09);
    wr(4'hF, 32'h0000_9000);
    chk("R8 code 9 drops word3 bit11", irq, 8'h09);
    wr(4'h2, 32'h0000_0005);
    chk("R7 word0 bit0 to irq5", irq, 8'h29);
    wr(4'hA, 32'h0090_0000);
    chk("R8 word2 bit5 nowhere", irq, 8'h28);

    wr(4'h5, 32'h0000_0080);
    rd_chk("R5 clear word1 bit7", 4'h4, 0);
    chk("R5 irq3 drops", irq, 8'h20);
    wr(4'h1, 32'h0000_0002);
    rd_chk("R5 zero bits untouched", 4'h0, 32'h1);

    valid = 1; ftype = 4'b1010; info = 16'h0000; we = 1; addr = 4'h1; wdata = 32'h1;
    tick(); idle();
    rd_chk("R6 set beats clear", 4'h0, 32'h1);

    wr(4'h0, 32'h0000_FFFF);
    rd_chk("R10 status write ignored", 4'h0, 32'h1);
    rd_chk("R10 clear reads zero", 4'h1, 0);

    for (int i = 0; i < 2000; i++) begin
      valid = ($urandom_range(0, 2) != 0);
      ftype = ($urandom_range(0, 4) != 0) ? 4'b1010 : 4'($urandom);
      info  = 16'($urandom);
      if ($urandom_range(0, 1) != 0) info &= 16'h006F;
      prio  = 2'($urandom); sid = 8'($urandom); stid = 8'($urandom);
      we    = ($urandom_range(0, 3) == 0);
      addr  = 4'($urandom);
      wdata = $urandom;
      tick();
    end
    idle();
    tick();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule